// File: doc/BRIEF.md
# SD Host Single-Segment DMA Sequencer

This block is the register front end and beat sequencer of a small DMA engine that sits inside an SD host controller. Software programs a mode word, a 64-bit start address, and a byte length through a 32-bit register port. It then writes a start bit. The engine issues one memory request per beat until the length is used up, raises a sticky done flag, and returns to idle.

Each beat is a request held until the memory side acknowledges it. Beats are 1, 2, 4 or 8 bytes wide. The address either advances by the beat size after each acknowledge or stays on one location. Only one contiguous segment is handled. A launch is refused, and an error flag is set with no traffic, when:

- the segment start is not a multiple of 8 bytes,
- the length is zero,
- the direction code is not defined, or
- card-to-memory is requested on a build that has no receive path.

Two active-low channel reset bits abort a running transfer. Software pulses them low and then high again.

Top module: `sdh_dma_seq`

## Requirements
- R1: After reset, every register reads 0 except the channel-reset register, which reads 0x300. No memory request is raised.
- R2: The mode register (0x410) holds three fields. Bits [17:16] are the direction: 0 moves memory to card (`mem_write`=0) and 1 moves card to memory (`mem_write`=1). Bits [5:4] are the beat size code w: the beat is 2^w bytes and `mem_size`=w. Bit 0 selects the address step: 1 increments, 0 keeps the address fixed. All other mode bits read 0.
- R3: The 64-bit start address is written as a low word at 0x440 and a high word at 0x444. Reads of these offsets return the live beat address.
- R4: The length register (0x420) holds a byte count truncated to LEN_W bits. A transfer makes ceil(length / 2^w) beats, and a read returns the bytes still to move.
- R5: Writing 1 to bit 0 of the control register (0x414) sets a start bit. That bit reads 1 for exactly one cycle and then clears itself, and the first request appears in the following cycle.
- R6: A request stays high with a stable address until `mem_ack`. After each acknowledged beat, the address advances by 2^w when stepping is on and is unchanged otherwise.
- R7: Status register 0x41C has three bits: bit 0 is done, bit 1 is error and bit 2 is busy. Done sets on the last acknowledged beat and holds until a 1 is written to bit 0.
- R8: A launch is refused when the address bits [2:0] are non-zero, the length is 0, direction bit 17 is set, or direction 1 is requested with RX_EN=0. A refused launch sets error (bit 1, cleared by writing 1) and raises no request.
- R9: Bits 9 and 8 of register 0x418 are active-low channel resets. While either bit is low, no request is raised, the transfer is dropped, and the address, length and start bit are held at 0. Done is not set.
- R10: While a transfer is pending or busy, writes to the mode, address and length registers and to the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| mem_req | output | 1 | Beat request, held until acknowledged |
| mem_addr | output | 64 | Beat address |
| mem_write | output | 1 | 1 when the beat writes memory (card to memory) |
| mem_size | output | 2 | Beat size code, 2^code bytes |
| mem_ack | input | 1 | Beat acknowledge |
| dma_busy | output | 1 | Transfer in progress |
| dma_done | output | 1 | Sticky done flag |
| dma_err | output | 1 | Sticky launch-refused flag |

## Verification
The bench builds the main instance with LEN_W=12 and RX_EN=1. At that width, a truncated length write gives a small, checkable value. The bench sweeps every combination of direction, beat size and step mode over four lengths, including lengths that are not multiples of the beat size. A second instance with RX_EN=0 shares the register bus and acknowledges every request at once. It shows that receive launches are refused while transmit launches still complete.

// File: rtl/sdh_dma_seq.sv
module sdh_dma_seq #(
  parameter int LEN_W = 26,
  parameter bit RX_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic [63:0] mem_addr,
  output logic        mem_write,
  output logic [1:0]  mem_size,
  input  logic        mem_ack,
  output logic        dma_busy,
  output logic        dma_done,
  output logic        dma_err
);
  localparam logic [11:0] A_MODE = 12'h410;
  localparam logic [11:0] A_CTL  = 12'h414;
  localparam logic [11:0] A_CRST = 12'h418;
  localparam logic [11:0] A_STAT = 12'h41C;
  localparam logic [11:0] A_LEN  = 12'h420;
  localparam logic [11:0] A_LO   = 12'h440;
  localparam logic [11:0] A_HI   = 12'h444;

  logic [1:0]       dir_q, wid_q, crst_q;
  logic             inc_q, start_q, busy_q, done_q, err_q;
  logic [63:0]      addr_q;
  logic [LEN_W-1:0] len_q;

  wire chan_rst = ~&crst_q;
  wire cfg_ok   = !busy_q && !start_q && !chan_rst;
  wire wr_mode  = reg_wr && reg_addr == A_MODE && cfg_ok;
  wire wr_ctl   = reg_wr && reg_addr == A_CTL && cfg_ok && reg_wdata[0];
  wire wr_len   = reg_wr && reg_addr == A_LEN && cfg_ok;
  wire wr_lo    = reg_wr && reg_addr == A_LO && cfg_ok;
  wire wr_hi    = reg_wr && reg_addr == A_HI && cfg_ok;
  wire clr_done = reg_wr && reg_addr == A_STAT && reg_wdata[0];
  wire clr_err  = reg_wr && reg_addr == A_STAT && reg_wdata[1];

  wire [3:0]       beat_b = 4'd1 << wid_q;
  wire [LEN_W-1:0] beat_l = LEN_W'(beat_b);
  wire last = len_q <= beat_l;
  wire bad  = (addr_q[2:0] != 3'd0) || (len_q == '0) || dir_q[1] ||
              (dir_q == 2'd1 && !RX_EN);
  wire step = busy_q && mem_ack && !chan_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0; wid_q <= '0; inc_q <= 1'b0; crst_q <= 2'b11;
      start_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      addr_q <= '0; len_q <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CRST) crst_q <= reg_wdata[9:8];
      if (wr_mode) begin
        dir_q <= reg_wdata[17:16];
        wid_q <= reg_wdata[5:4];
        inc_q <= reg_wdata[0];
      end
      if (chan_rst) begin
        start_q <= 1'b0; busy_q <= 1'b0; addr_q <= '0; len_q <= '0;
      end else begin
        start_q <= wr_ctl;
        if (start_q) busy_q <= !bad;
        if (step) begin
          if (inc_q) addr_q <= addr_q + 64'(beat_b);
          len_q <= last ? '0 : len_q - beat_l;
          if (last) busy_q <= 1'b0;
        end
        if (wr_lo)  addr_q[31:0]  <= reg_wdata;
        if (wr_hi)  addr_q[63:32] <= reg_wdata;
        if (wr_len) len_q <= reg_wdata[LEN_W-1:0];
      end
      if (step && last) done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
      if (start_q && bad && !chan_rst) err_q <= 1'b1;
      else if (clr_err) err_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = {14'd0, dir_q, 10'd0, wid_q, 3'd0, inc_q};
      A_CTL:   reg_rdata = {31'd0, start_q};
      A_CRST:  reg_rdata = {22'd0, crst_q, 8'd0};
      A_STAT:  reg_rdata = {29'd0, busy_q, err_q, done_q};
      A_LEN:   reg_rdata = 32'(len_q);
      A_LO:    reg_rdata = addr_q[31:0];
      A_HI:    reg_rdata = addr_q[63:32];
      default: reg_rdata = 32'd0;
    endcase
  end

  assign mem_req   = busy_q && !chan_rst;
  assign mem_addr  = addr_q;
  assign mem_write = dir_q[0];
  assign mem_size  = wid_q;
  assign dma_busy  = busy_q;
  assign dma_done  = done_q;
  assign dma_err   = err_q;
endmodule

// File: rtl/sdh_dma_seq_chk.sv
module sdh_dma_seq_chk #(
  parameter bit RX_EN = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [11:0] reg_addr,
  input logic [31:0] reg_wdata,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [63:0] mem_addr,
  input logic        mem_write,
  input logic        inc_q,
  input logic        start_q,
  input logic        chan_rst,
  input logic        dma_busy,
  input logic        dma_done
);
  wire crst_wr = reg_wr && reg_addr == 12'h418;

  AST_START_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);  // R5

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !crst_wr |=> mem_req && $stable(mem_addr));  // R6

  AST_FIXED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !inc_q && !crst_wr |=> $stable(mem_addr));  // R6

  AST_ALIGNED_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> mem_addr[2:0] == 3'd0);  // R8

  AST_NO_RX_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    !RX_EN && mem_req |-> !mem_write);  // R8

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done && !(reg_wr && reg_addr == 12'h41C && reg_wdata[0]) |=> dma_done);  // R7

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> !dma_busy);  // R9
endmodule

bind sdh_dma_seq sdh_dma_seq_chk #(.RX_EN(RX_EN)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_write(mem_write), .inc_q(inc_q),
  .start_q(start_q), .chan_rst(chan_rst), .dma_busy(dma_busy),
  .dma_done(dma_done)
);

// File: tb/sdh_dma_seq_tb.sv
module sdh_dma_seq_tb;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        mem_ack = 1'b0;
  logic [31:0] rdata, rdata_b;
  logic        mem_req, mem_write, busy, done, err;
  logic [63:0] mem_addr;
  logic [1:0]  mem_size;
  logic        req_b, wr_b, busy_b, done_b, err_b;
  logic [63:0] addr_b;
  logic [1:0]  size_b;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  sdh_dma_seq #(.LEN_W(12), .RX_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_write(mem_write), .mem_size(mem_size),
    .mem_ack(mem_ack), .dma_busy(busy), .dma_done(done), .dma_err(err));

  sdh_dma_seq #(.LEN_W(12), .RX_EN(1'b0)) u_dut_norx (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_b), .mem_req(req_b),
    .mem_addr(addr_b), .mem_write(wr_b), .mem_size(size_b),
    .mem_ack(req_b), .dma_busy(busy_b), .dma_done(done_b), .dma_err(err_b));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = rdata;
  endtask

  task automatic run_xfer(int dir, int w, int inc, int len, logic [63:0] base, int gap);
    logic [31:0] v;
    logic [63:0] exp;
    int bytes, beats, cnt;
    bytes = 1 << w;
    wr(12'h410, (dir << 16) | (w << 4) | inc);
    wr(12'h440, base[31:0]);
    wr(12'h444, base[63:32]);
    wr(12'h420, len);
    wr(12'h414, 32'h1);
    rd(12'h414, v); check("R5 start reads 1", v, 1);
    @(negedge clk);
    rd(12'h414, v); check("R5 start self-clears", v, 0);
    check("R5 request follows start", mem_req, 1);
    exp = base; beats = 0; cnt = 0;
    for (int i = 0; i < 4000; i++) begin
      if (!mem_req) break;
      check("R6 beat address", mem_addr, exp);
      check("R2 direction", mem_write, dir);
      check("R2 size", mem_size, w);
      if (cnt < gap) begin mem_ack = 1'b0; cnt++; end
      else begin
        mem_ack = 1'b1; cnt = 0; beats++;
        if (inc != 0) exp = exp + bytes;
      end
      @(negedge clk);
    end
    mem_ack = 1'b0;
    check("R4 beat count", beats, (len + bytes - 1) / bytes);
    rd(12'h41C, v); check("R7 done set, busy clear", v, 32'h1);
    rd(12'h440, v); check("R3 final address low", v, exp[31:0]);
    rd(12'h444, v); check("R3 final address high", v, exp[63:32]);
    rd(12'h420, v); check("R4 remaining zero", v, 0);
    wr(12'h41C, 32'h1);
    rd(12'h41C, v); check("R7 done cleared by W1C", v, 0);
  endtask

  task automatic refused(string req);
    logic [31:0] v;
    wr(12'h414, 32'h1);
    repeat (3) begin
      @(negedge clk);
      check({req, " no request"}, mem_req, 0);
    end
    rd(12'h41C, v); check({req, " error set"}, v, 32'h2);
    wr(12'h41C, 32'h2);
    rd(12'h41C, v); check({req, " error cleared"}, v, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [63:0] base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd(12'h410, v); check("R1 mode", v, 0);
    rd(12'h414, v); check("R1 ctl", v, 0);
    rd(12'h418, v); check("R1 channel reset", v, 32'h300);
    rd(12'h41C, v); check("R1 status", v, 0);
    rd(12'h420, v); check("R1 length", v, 0);
    rd(12'h440, v); check("R1 addr low", v, 0);
    rd(12'h444, v); check("R1 addr high", v, 0);
    check("R1 no request", mem_req, 0);

    // R2 field masking, R4 truncation
    wr(12'h410, 32'hFFFF_FFFF);
    rd(12'h410, v); check("R2 mode fields", v, 32'h0003_0031);
    wr(12'h420, 32'h0001_2028);
    rd(12'h420, v); check("R4 length truncated", v, 32'h028);

    // R2 R3 R4 R6 R7 sweep
    for (int dir = 0; dir < 2; dir++)
      for (int w = 0; w < 4; w++)
        for (int inc = 0; inc < 2; inc++)
          for (int k = 0; k < 4; k++) begin
            int lens[4] = '{1, 8, 13, 40};
            base = 64'hA5A5_0001_0000_0040 + 64'(w * 64 + k * 8);
            run_xfer(dir, w, inc, lens[k], base, (w + k) % 3);
          end

    // R8 refused launches
    wr(12'h410, 32'h0000_0031);
    wr(12'h444, 32'h0);
    wr(12'h440, 32'h0000_1004);
    wr(12'h420, 32'd16);
    refused("R8 unaligned");
    wr(12'h440, 32'h0000_1000);
    wr(12'h420, 32'd0);
    refused("R8 zero length");
    wr(12'h420, 32'd16);
    wr(12'h410, 32'h0002_0031);
    refused("R8 undefined direction");

    // R8 receive disabled on second instance, transmit still works there
    wr(12'h41C, 32'h3);
    wr(12'h410, 32'h0001_0031);
    wr(12'h414, 32'h1);
    repeat (3) @(negedge clk);
    check("R8 rx refused without receive path", err_b, 1);
    check("R8 rx no done without receive path", done_b, 0);
    check("R8 rx accepted with receive path", busy, 1);
    mem_ack = 1'b1;
    repeat (3) @(negedge clk);
    mem_ack = 1'b0;
    wr(12'h41C, 32'h3);
    wr(12'h410, 32'h0000_0031);
    wr(12'h414, 32'h1);
    repeat (4) @(negedge clk);
    check("R8 tx completes without receive path", done_b, 1);
    mem_ack = 1'b1;
    repeat (3) @(negedge clk);
    mem_ack = 1'b0;
    wr(12'h41C, 32'h3);

    // R10 writes ignored while busy
    wr(12'h440, 32'h0000_2000);
    wr(12'h420, 32'd64);
    wr(12'h414, 32'h1);
    @(negedge clk);
    wr(12'h420, 32'd5);
    wr(12'h440, 32'h0000_3000);
    wr(12'h410, 32'h0000_0000);
    rd(12'h420, v); check("R10 length held while busy", v, 32'd64);
    rd(12'h440, v); check("R10 address held while busy", v, 32'h2000);
    rd(12'h410, v); check("R10 mode held while busy", v, 32'h31);
    check("R10 request still pending", mem_req, 1);

    // R9 channel reset abort
    wr(12'h418, 32'h0);
    check("R9 request dropped", mem_req, 0);
    @(negedge clk);
    wr(12'h420, 32'd7);
    rd(12'h420, v); check("R9 length cleared", v, 0);
    rd(12'h440, v); check("R9 address cleared", v, 0);
    rd(12'h41C, v); check("R9 idle, no done", v, 0);
    rd(12'h418, v); check("R9 reset bits read low", v, 0);
    wr(12'h418, 32'hFFFF_FFFF);
    rd(12'h418, v); check("R9 reset bits restored", v, 32'h300);
    wr(12'h420, 32'd9);
    rd(12'h420, v); check("R9 length writable again", v, 32'd9);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule